// File: doc/BRIEF.md
# Key Matrix Responder with Paced Event Queue

This block stands in for a physical scanned keyboard. A host controller drives a vector of strobe (column) lines, and the block answers on its sense (row) lines with the state of the keys that are currently held down. Key events arrive as 8-bit position codes. They wait in a small FIFO and are taken out and applied to the held-key state one at a time, at a slow fixed rate set by a tick timer. The host scan logic therefore sees key changes at a realistic pace, even when a burst of events arrives.

One position row has no physical keys. Events addressed to it drive five standalone status outputs, each through its own polarity-inversion input. A restore input drops every held key at once. It leaves the queue and the status outputs untouched.

Top module: `kbd_matrix_responder`

## Requirements
- R1: After reset, all sense outputs and all status outputs are 0, and the overflow flag is 0.
- R2: `sense_o[i]` is 1 exactly when row i has at least one held key whose column strobe in `strobe_i` is 1. The output follows `strobe_i` within the same cycle and is 0 whenever `strobe_i` is all zero.
- R3: An event code carries the column in bits [3:0], the row in bits [6:4] and a release flag in bit 7. For rows 0 to 6 and columns 0 to 10, a press (bit 7 = 0) marks the key held and a release (bit 7 = 1) marks it free.
- R4: Queued events are applied in arrival order. At most one event is applied per tick, and ticks come every `TICK_CYCLES` clock cycles. The effect of an applied event shows on the outputs in the cycle after its tick.
- R5: The queue holds 16 pending events. An event that arrives while 16 events are pending is discarded, and `overflow_o` is set. `overflow_o` stays set until reset.
- R6: An event with row 7 and column c in the range 0 to 4 sets `special_o[c]` to (press XOR `special_inv_i[c]`), with `special_inv_i` sampled when the event is applied. Such an event leaves the key matrix unchanged.
- R7: An event whose column is 11 to 15 in rows 0 to 6, or 5 to 15 in row 7, changes neither the matrix nor the status outputs.
- R8: One cycle of `restore_i` frees every held key by the next cycle. Pending events and the status outputs are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 11 | Column strobe vector driven by the host |
| evt_valid_i | input | 1 | Event code valid this cycle |
| evt_code_i | input | 8 | Event code: release flag, row, column |
| special_inv_i | input | 5 | Polarity inversion for each status output |
| restore_i | input | 1 | Free all held keys |
| sense_o | output | 7 | Row sense lines |
| special_o | output | 5 | Status outputs driven by row-7 events |
| overflow_o | output | 1 | Sticky flag: an event was discarded on a full queue |

## Verification
The hardest state to reach from the ports is a full queue that receives yet another event. The timer keeps draining the queue, so the fill has to outpace it. The bench sets a tick period of 64 cycles and pushes 20 distinct key presses on consecutive cycles, so at most one event can leave during the burst. Once the queue has drained, it scans the columns one at a time and checks that the first 16 keys are held and that the last three were discarded. The pacing check times each sense change under an all-ones strobe and expects exactly one tick period between them.

// File: rtl/kbdm_pkg.sv
package kbdm_pkg;

    localparam int CODE_W = 8;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 4;

    // Event code layout: release flag on top, then row, then column.
    typedef struct packed {
        logic             rel;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } key_evt_t;

endpackage

// File: rtl/kbdm_event_queue.sv
module kbdm_event_queue #(
    parameter int DEPTH       = 16,       // power of two
    parameter int CODE_W      = 8,
    parameter int TICK_CYCLES = 1562500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid_i,
    input  logic [CODE_W-1:0] push_code_i,
    output logic              pop_valid_o,
    output logic [CODE_W-1:0] pop_code_o,
    output logic              overflow_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TCW   = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][CODE_W-1:0] mem;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             count;
        logic [TCW-1:0]               tick_cnt;
        logic                         overflow;
    } q_state_t;

    q_state_t st_d, st_q;
    logic tick, full, push, pop;
    logic [PTR_W-1:0] wr_ptr;

    always_comb begin
        tick   = (st_q.tick_cnt == TCW'(TICK_CYCLES - 1));
        full   = (st_q.count == CNT_W'(DEPTH));
        pop    = tick && (st_q.count != '0);
        push   = push_valid_i && !full;
        wr_ptr = st_q.rd_ptr + PTR_W'(st_q.count);

        st_d = st_q;
        st_d.tick_cnt = tick ? '0 : st_q.tick_cnt + TCW'(1);
        if (push) begin
            st_d.mem[wr_ptr] = push_code_i;
        end
        if (pop) begin
            st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
        end
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
        if (push_valid_i && full) begin
            st_d.overflow = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_valid_o = pop;
    assign pop_code_o  = st_q.mem[st_q.rd_ptr];
    assign overflow_o  = st_q.overflow;

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    p_overflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    p_drop_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid_i && st_q.count == CNT_W'(DEPTH)) |=> overflow_o);

    p_single_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count < $past(st_q.count)) |-> (($past(st_q.count) - st_q.count) == CNT_W'(1)));

    p_pop_restarts_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid_o |=> (st_q.tick_cnt == '0));

endmodule

// File: rtl/kbdm_key_state.sv
module kbdm_key_state
    import kbdm_pkg::*;
#(
    parameter int ROWS     = 7,
    parameter int COLS     = 11,
    parameter int SPECIALS = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      apply_valid_i,
    input  logic [CODE_W-1:0]         apply_code_i,
    input  logic [SPECIALS-1:0]       special_inv_i,
    input  logic                      restore_i,
    output logic [ROWS-1:0][COLS-1:0] held_o,
    output logic [SPECIALS-1:0]       special_o
);

    typedef struct packed {
        logic [ROWS-1:0][COLS-1:0] held;
        logic [SPECIALS-1:0]       special;
    } ks_state_t;

    ks_state_t st_d, st_q;
    key_evt_t  ev;

    always_comb begin
        ev   = key_evt_t'(apply_code_i);
        st_d = st_q;
        if (apply_valid_i) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (int'(ev.row) == r && int'(ev.col) == c) begin
                        st_d.held[r][c] = ~ev.rel;
                    end
                end
            end
            for (int s = 0; s < SPECIALS; s++) begin
                if (int'(ev.row) == ROWS && int'(ev.col) == s) begin
                    st_d.special[s] = ~ev.rel ^ special_inv_i[s];
                end
            end
        end
        if (restore_i) begin
            st_d.held = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o    = st_q.held;
    assign special_o = st_q.special;

    p_restore_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (held_o == '0));

    p_matrix_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_valid_i && !restore_i) |=> $stable(held_o));

    p_special_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_valid_i |=> $stable(special_o));

endmodule

// File: rtl/kbdm_sense.sv
module kbdm_sense #(
    parameter int ROWS = 7,
    parameter int COLS = 11
) (
    input  logic [ROWS-1:0][COLS-1:0] held_i,
    input  logic [COLS-1:0]           strobe_i,
    output logic [ROWS-1:0]           sense_o
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign sense_o[r] = |(held_i[r] & strobe_i);
    end

endmodule

// File: rtl/kbd_matrix_responder.sv
module kbd_matrix_responder
    import kbdm_pkg::*;
#(
    parameter int ROWS        = 7,
    parameter int COLS        = 11,
    parameter int SPECIALS    = 5,
    parameter int QDEPTH      = 16,
    parameter int TICK_CYCLES = 1562500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COLS-1:0]     strobe_i,
    input  logic                evt_valid_i,
    input  logic [CODE_W-1:0]   evt_code_i,
    input  logic [SPECIALS-1:0] special_inv_i,
    input  logic                restore_i,
    output logic [ROWS-1:0]     sense_o,
    output logic [SPECIALS-1:0] special_o,
    output logic                overflow_o
);

    logic                      pop_valid;
    logic [CODE_W-1:0]         pop_code;
    logic [ROWS-1:0][COLS-1:0] held;

    kbdm_event_queue #(
        .DEPTH       (QDEPTH),
        .CODE_W      (CODE_W),
        .TICK_CYCLES (TICK_CYCLES)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid_i (evt_valid_i),
        .push_code_i  (evt_code_i),
        .pop_valid_o  (pop_valid),
        .pop_code_o   (pop_code),
        .overflow_o   (overflow_o)
    );

    kbdm_key_state #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .SPECIALS (SPECIALS)
    ) u_keys (
        .clk           (clk),
        .rst_n         (rst_n),
        .apply_valid_i (pop_valid),
        .apply_code_i  (pop_code),
        .special_inv_i (special_inv_i),
        .restore_i     (restore_i),
        .held_o        (held),
        .special_o     (special_o)
    );

    kbdm_sense #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_sense (
        .held_i   (held),
        .strobe_i (strobe_i),
        .sense_o  (sense_o)
    );

    p_no_strobe_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i == '0) |-> (sense_o == '0));

endmodule

// File: tb/kbd_matrix_responder_tb.sv
module kbd_matrix_responder_tb;

    localparam int TICK = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] strobe_i = '0;
    logic        evt_valid_i = 1'b0;
    logic [7:0]  evt_code_i = '0;
    logic [4:0]  special_inv_i = '0;
    logic        restore_i = 1'b0;
    logic [6:0]  sense_o;
    logic [4:0]  special_o;
    logic        overflow_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [6:0][10:0] m_held;
    logic [4:0]       m_spec;

    always #10 clk = ~clk;

    kbd_matrix_responder #(.TICK_CYCLES(TICK)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_i      (strobe_i),
        .evt_valid_i   (evt_valid_i),
        .evt_code_i    (evt_code_i),
        .special_inv_i (special_inv_i),
        .restore_i     (restore_i),
        .sense_o       (sense_o),
        .special_o     (special_o),
        .overflow_o    (overflow_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_sense(input logic [10:0] stb);
        logic [6:0] s;
        for (int r = 0; r < 7; r++) s[r] = |(m_held[r] & stb);
        return s;
    endfunction

    function automatic void model_apply(input logic [7:0] c, input logic [4:0] inv);
        int row, col;
        row = int'(c[6:4]);
        col = int'(c[3:0]);
        if (row < 7 && col < 11) m_held[row][col] = ~c[7];
        else if (row == 7 && col < 5) m_spec[col] = ~c[7] ^ inv[col];
    endfunction

    task automatic check_matrix(input string req);
        for (int c = 0; c < 11; c++) begin
            strobe_i = 11'(1) << c;
            #1;
            chk(sense_o == exp_sense(strobe_i), req, 32'(sense_o), 32'(exp_sense(strobe_i)));
        end
    endtask

    task automatic push_one(input logic [7:0] c);
        @(negedge clk);
        evt_valid_i = 1'b1;
        evt_code_i  = c;
        @(negedge clk);
        evt_valid_i = 1'b0;
    endtask

    task automatic do_restore;
        @(negedge clk);
        restore_i = 1'b1;
        @(negedge clk);
        restore_i = 1'b0;
        m_held = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  code;
        logic [10:0] stb;
        int          t_prev, t_now, n_seen;
        logic [6:0]  last;
        void'($urandom(32'd20240611));
        m_held = '0;
        m_spec = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strobe_i = '1;
        #1;
        // R1: reset state
        chk(sense_o == '0, "R1 sense", 32'(sense_o), 0);
        chk(special_o == '0, "R1 special", 32'(special_o), 0);
        chk(overflow_o == 1'b0, "R1 overflow", 32'(overflow_o), 0);

        // R3: directed press and release of a corner key (row 6, col 10)
        push_one(8'h6A);
        repeat (2*TICK+4) @(negedge clk);
        model_apply(8'h6A, special_inv_i);
        check_matrix("R3 press corner");
        push_one(8'hEA);
        repeat (2*TICK+4) @(negedge clk);
        model_apply(8'hEA, special_inv_i);
        check_matrix("R3 release corner");

        // R7: out-of-range columns in key rows and the special row
        push_one(8'h2C);
        push_one(8'h75);
        repeat (3*TICK+4) @(negedge clk);
        check_matrix("R7 ignored key column");
        chk(special_o == m_spec, "R7 ignored special column", 32'(special_o), 32'(m_spec));

        // R6: special output with and without inversion
        special_inv_i = 5'b00100;
        push_one(8'h72);
        repeat (2*TICK+4) @(negedge clk);
        model_apply(8'h72, special_inv_i);
        chk(special_o == m_spec, "R6 inverted press", 32'(special_o), 32'(m_spec));
        push_one(8'h70);
        repeat (2*TICK+4) @(negedge clk);
        model_apply(8'h70, special_inv_i);
        chk(special_o == m_spec, "R6 plain press", 32'(special_o), 32'(m_spec));
        check_matrix("R6 matrix untouched");

        // R4: pacing and order of three queued presses
        do_restore();
        strobe_i = '1;
        @(negedge clk);
        evt_valid_i = 1'b1; evt_code_i = 8'h00;
        @(negedge clk);
        evt_code_i = 8'h10;
        @(negedge clk);
        evt_code_i = 8'h20;
        @(negedge clk);
        evt_valid_i = 1'b0;
        t_prev = 0; n_seen = 0; last = sense_o;
        for (int t = 1; t < 5*TICK; t++) begin
            @(negedge clk);
            #1;
            if (sense_o != last) begin
                n_seen++;
                if (n_seen == 1) begin
                    chk(sense_o == 7'b0000001, "R4 first applied", 32'(sense_o), 1);
                    chk(t <= TICK + 1, "R4 first within a tick", 32'(t), TICK + 1);
                end else if (n_seen == 2) begin
                    chk(sense_o == 7'b0000011, "R4 second applied", 32'(sense_o), 3);
                    chk(t - t_prev == TICK, "R4 spacing 1-2", 32'(t - t_prev), TICK);
                end else if (n_seen == 3) begin
                    chk(sense_o == 7'b0000111, "R4 third applied", 32'(sense_o), 7);
                    chk(t - t_prev == TICK, "R4 spacing 2-3", 32'(t - t_prev), TICK);
                end
                t_prev = t;
                last = sense_o;
            end
        end
        chk(n_seen == 3, "R4 change count", 32'(n_seen), 3);
        m_held[0][0] = 1'b1; m_held[1][0] = 1'b1; m_held[2][0] = 1'b1;

        // R8: restore frees keys, leaves specials
        do_restore();
        strobe_i = '1;
        #1;
        chk(sense_o == '0, "R8 all free", 32'(sense_o), 0);
        chk(special_o == m_spec, "R8 specials kept", 32'(special_o), 32'(m_spec));
        chk(overflow_o == 1'b0, "R5 no overflow yet", 32'(overflow_o), 0);

        // R5: burst of 20 distinct presses against a full queue
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            evt_valid_i = 1'b1;
            evt_code_i  = {1'b0, 3'(k % 7), 4'(k / 7)};
        end
        @(negedge clk);
        evt_valid_i = 1'b0;
        #1;
        chk(overflow_o == 1'b1, "R5 overflow set", 32'(overflow_o), 1);
        repeat (20*TICK) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            if (k != 16) begin
                strobe_i = 11'(1) << (k / 7);
                #1;
                chk(sense_o[k % 7] == (k < 16), "R5 kept/dropped key",
                    32'(sense_o[k % 7]), 32'(k < 16));
                if (k < 16) m_held[k % 7][k / 7] = 1'b1;
            end
        end
        do_restore();
        chk(overflow_o == 1'b1, "R5 overflow sticky", 32'(overflow_o), 1);

        // Random phase: R2, R3, R6, R7
        for (int it = 0; it < 150; it++) begin
            code = 8'($urandom);
            if (it % 10 == 0) special_inv_i = 5'($urandom);
            push_one(code);
            repeat (2*TICK+4) @(negedge clk);
            model_apply(code, special_inv_i);
            chk(special_o == m_spec, "R6 random special", 32'(special_o), 32'(m_spec));
            check_matrix("R3 random matrix");
            for (int j = 0; j < 3; j++) begin
                stb = 11'($urandom);
                strobe_i = stb;
                #1;
                chk(sense_o == exp_sense(stb), "R2 random strobe", 32'(sense_o), 32'(exp_sense(stb)));
            end
            strobe_i = '0;
            #1;
            chk(sense_o == '0, "R2 no strobe", 32'(sense_o), 0);
            if (it % 25 == 24) begin
                do_restore();
                strobe_i = '1;
                #1;
                chk(sense_o == '0, "R8 random restore", 32'(sense_o), 0);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule